// File: doc/BRIEF.md
# Queued Memory Copy Engine with Loopback

This block accepts memory transfer commands through a small register port, holds them in a short in-order queue, and executes them one at a time over a single word-wide memory request/response port. Software writes the source address, the destination address and the two lengths (counted in 32-bit words). The act of writing the destination length captures all four values as one command and queues it. The addresses are forced to word alignment at capture.

The engine splits each command into bursts. A burst is capped by a fixed maximum byte count and by the remaining source length. In loopback mode it is also capped by the remaining destination length. A burst first reads all of its words into a local buffer. In loopback mode it then writes the same words, in the same order, to the destination. Outside loopback, every word read is presented once on a data sink output, and no memory writes are made.

When a command finishes, two status bits are set and the command leaves the queue. A third status bit records a command that was rejected because the queue was full. The interrupt output is asserted while any status bit is set whose mask bit is clear. Status bits are cleared by writing ones to them.

Top module: `qdma_loop`

## Requirements
- R1: A write to the destination-length register (offset 0x0C) queues one command built from the current source address (0x00), destination address (0x04), source length (0x08) and the value being written. Both addresses are captured with bits 1:0 cleared. Writes to any other offset queue nothing.
- R2: The two length registers keep only bits 26:0 of a write and read back zero in bits 31:27.
- R3: Each burst moves n = min(BURST_BYTES/4, remaining source words) words, and in loopback n is also at most the remaining destination words. Within a burst the n reads go to consecutive word addresses from the current source address. After the burst the source address advances by 4n and the remaining source length shrinks by n.
- R4: In loopback (misc register 0x1C bit 4 set when the command starts), the n reads of a burst are followed by n writes to consecutive word addresses from the current destination address, carrying the read data in read order. The destination then advances by 4n and its remaining length shrinks by n. Outside loopback no write requests are issued, and each read word is shown once on sink_valid/sink_data.
- R5: A command retires when its remaining source length is zero, or, in loopback, when its remaining destination length is zero. A command with zero source length retires with no memory traffic.
- R6: Retiring a command sets status bits 13 and 12 (offset 0x10). Commands are executed and retired in the order they were queued.
- R7: Queue status (offset 0x18) reads bit 30 set when no command is held and bit 31 set when DEPTH commands are held. After reset it reads 0x4000_0000.
- R8: A queueing write that arrives while the queue holds DEPTH commands is discarded and sets status bit 14.
- R9: irq is high exactly when some status bit is set whose bit in the mask register (offset 0x14) is zero. The mask resets to all ones. Writing a one to a status bit clears it, unless the same cycle sets it again.
- R10: In the misc register only bit 4 is writable. All of its other bits read zero.
- R11: At most one memory request is outstanding. A new mem_req is issued only after the mem_rsp_valid for the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | One-cycle memory request pulse |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rdata | input | 32 | Read response data |
| sink_valid | output | 1 | Read word delivered to the sink (not in loopback) |
| sink_data | output | 32 | Sink word |
| irq | output | 1 | Masked interrupt |

## Verification
The bench sweeps every pair of source and destination lengths from 0 to 6 words, in both modes, with a four-word burst cap. Unaligned addresses are used and memory latency varies, and the full request sequence is compared against an arithmetic model. A design that sizes bursts wrongly shows reads and writes interleaved at the wrong points. One that ignores the destination length in loopback, or fails to retire a command whose lengths differ, either writes past the destination or never empties its queue. The queue is filled while memory is stalled, to show that the fifth command is dropped and flagged and that the other four run in order. The interrupt is checked against mask changes and clearing writes, so a design that inverts the mask or loses status bits fails there.

// File: rtl/qdma_pkg.sv
package qdma_pkg;

  localparam int unsigned LEN_W = 27;

  // register word offsets (reg_addr[4:2])
  localparam logic [2:0] OFS_SRC   = 3'd0;
  localparam logic [2:0] OFS_DST   = 3'd1;
  localparam logic [2:0] OFS_SLEN  = 3'd2;
  localparam logic [2:0] OFS_DLEN  = 3'd3;
  localparam logic [2:0] OFS_STAT  = 3'd4;
  localparam logic [2:0] OFS_MASK  = 3'd5;
  localparam logic [2:0] OFS_QSTAT = 3'd6;
  localparam logic [2:0] OFS_MISC  = 3'd7;

  // bit positions
  localparam int unsigned BIT_PDONE = 12;
  localparam int unsigned BIT_DONE  = 13;
  localparam int unsigned BIT_QOVF  = 14;
  localparam int unsigned BIT_EMPTY = 30;
  localparam int unsigned BIT_FULL  = 31;
  localparam int unsigned BIT_LOOP  = 4;

  typedef struct packed {
    logic [31:0]      src;
    logic [31:0]      dst;
    logic [LEN_W-1:0] slen;
    logic [LEN_W-1:0] dlen;
  } qdma_cmd_t;

  function automatic logic [31:0] word_align(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction

  // words in the next burst
  function automatic logic [LEN_W-1:0] burst_len(input logic [LEN_W-1:0] srem,
                                                 input logic [LEN_W-1:0] drem,
                                                 input logic             loop,
                                                 input logic [LEN_W-1:0] cap);
    logic [LEN_W-1:0] n;
    n = (srem < cap) ? srem : cap;
    if (loop && (drem < n)) n = drem;
    return n;
  endfunction

  function automatic logic cmd_finished(input logic [LEN_W-1:0] srem,
                                        input logic [LEN_W-1:0] drem,
                                        input logic             loop);
    return (srem == '0) || (loop && (drem == '0));
  endfunction

endpackage

// File: rtl/qdma_regs.sv
module qdma_regs
  import qdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        q_full,
  input  logic        q_empty,
  input  logic        ev_retire,
  output logic        push,
  output qdma_cmd_t   push_cmd,
  output logic        ev_overflow,
  output logic        loop_cfg,
  output logic [31:0] mask_q,
  output logic [2:0]  stat_q,
  output logic        irq
);

  logic [31:0]      src_q, dst_q;
  logic [LEN_W-1:0] slen_q, dlen_q;
  logic [2:0]       stat_set, stat_clr;
  logic [2:0]       mask_bits;
  wire  [2:0]       word = reg_addr[4:2];

  assign push        = reg_we && (word == OFS_DLEN);
  assign ev_overflow = push && q_full;
  assign push_cmd    = '{src:  word_align(src_q),
                         dst:  word_align(dst_q),
                         slen: slen_q,
                         dlen: reg_wdata[LEN_W-1:0]};

  // stat_q[2]=overflow, [1]=done, [0]=part done
  assign stat_set = {ev_overflow, ev_retire, ev_retire};
  assign stat_clr = (reg_we && (word == OFS_STAT)) ?
                    reg_wdata[BIT_QOVF:BIT_PDONE] : 3'b000;
  assign mask_bits = mask_q[BIT_QOVF:BIT_PDONE];
  assign irq       = |(stat_q & ~mask_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= '0;
      dst_q    <= '0;
      slen_q   <= '0;
      dlen_q   <= '0;
      mask_q   <= '1;
      stat_q   <= '0;
      loop_cfg <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | stat_set;
      if (reg_we) begin
        case (word)
          OFS_SRC:  src_q    <= reg_wdata;
          OFS_DST:  dst_q    <= reg_wdata;
          OFS_SLEN: slen_q   <= reg_wdata[LEN_W-1:0];
          OFS_DLEN: dlen_q   <= reg_wdata[LEN_W-1:0];
          OFS_MASK: mask_q   <= reg_wdata;
          OFS_MISC: loop_cfg <= reg_wdata[BIT_LOOP];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (word)
      OFS_SRC:   reg_rdata = src_q;
      OFS_DST:   reg_rdata = dst_q;
      OFS_SLEN:  reg_rdata = 32'(slen_q);
      OFS_DLEN:  reg_rdata = 32'(dlen_q);
      OFS_STAT:  reg_rdata[BIT_QOVF:BIT_PDONE] = stat_q;
      OFS_MASK:  reg_rdata = mask_q;
      OFS_QSTAT: begin
        reg_rdata[BIT_FULL]  = q_full;
        reg_rdata[BIT_EMPTY] = q_empty;
      end
      OFS_MISC:  reg_rdata[BIT_LOOP] = loop_cfg;
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/qdma_cmdq.sv
module qdma_cmdq
  import qdma_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  qdma_cmd_t push_cmd,
  input  logic      pop,
  output qdma_cmd_t head,
  output logic      full,
  output logic      empty
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  qdma_cmd_t       slots [DEPTH];
  logic [PW-1:0]   wp_q, rp_q;
  logic [CW-1:0]   cnt_q;
  logic            do_push, do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slots[rp_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= ptr_next(wp_q);
      if (do_pop)  rp_q <= ptr_next(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[wp_q] <= push_cmd;
  end

endmodule

// File: rtl/qdma_mover.sv
module qdma_mover
  import qdma_pkg::*;
#(
  parameter int unsigned BURST_WORDS = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  qdma_cmd_t   head,
  input  logic        q_empty,
  input  logic        loop_cfg,
  output logic        pop,
  output logic        lb_active,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rdata,
  output logic        sink_valid,
  output logic [31:0] sink_data
);

  localparam int unsigned NW = $clog2(BURST_WORDS + 1);
  localparam int unsigned IW = $clog2(BURST_WORDS);

  typedef enum logic [2:0] {
    S_IDLE, S_PLAN, S_RDREQ, S_RDWAIT, S_WRREQ, S_WRWAIT, S_ADV, S_RETIRE
  } mv_state_t;

  mv_state_t        state_q;
  logic [31:0]      src_q, dst_q;
  logic [LEN_W-1:0] srem_q, drem_q;
  logic             lb_q;
  logic [NW-1:0]    n_q;
  logic [IW-1:0]    idx_q;
  logic [31:0]      buf_q [BURST_WORDS];
  logic [NW-1:0]    plan_n;
  logic             last_word;
  logic [31:0]      step;

  assign plan_n    = NW'(burst_len(srem_q, drem_q, lb_q, LEN_W'(BURST_WORDS)));
  assign last_word = (NW'(idx_q) == (n_q - NW'(1)));
  assign step      = 32'(n_q) << 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      srem_q  <= '0;
      drem_q  <= '0;
      lb_q    <= 1'b0;
      n_q     <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (!q_empty) begin
          src_q   <= head.src;
          dst_q   <= head.dst;
          srem_q  <= head.slen;
          drem_q  <= head.dlen;
          lb_q    <= loop_cfg;
          state_q <= S_PLAN;
        end
        S_PLAN: begin
          idx_q <= '0;
          n_q   <= plan_n;
          state_q <= cmd_finished(srem_q, drem_q, lb_q) ? S_RETIRE : S_RDREQ;
        end
        S_RDREQ: state_q <= S_RDWAIT;
        S_RDWAIT: if (mem_rsp_valid) begin
          if (last_word) begin
            idx_q   <= '0;
            state_q <= lb_q ? S_WRREQ : S_ADV;
          end else begin
            idx_q   <= idx_q + IW'(1);
            state_q <= S_RDREQ;
          end
        end
        S_WRREQ: state_q <= S_WRWAIT;
        S_WRWAIT: if (mem_rsp_valid) begin
          if (last_word) begin
            state_q <= S_ADV;
          end else begin
            idx_q   <= idx_q + IW'(1);
            state_q <= S_WRREQ;
          end
        end
        S_ADV: begin
          src_q  <= src_q + step;
          srem_q <= srem_q - LEN_W'(n_q);
          if (lb_q) begin
            dst_q  <= dst_q + step;
            drem_q <= drem_q - LEN_W'(n_q);
          end
          state_q <= S_PLAN;
        end
        S_RETIRE: state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == S_RDWAIT && mem_rsp_valid) buf_q[idx_q] <= mem_rdata;
  end

  assign mem_req    = (state_q == S_RDREQ) || (state_q == S_WRREQ);
  assign mem_we     = (state_q == S_WRREQ);
  assign mem_addr   = ((state_q == S_WRREQ) ? dst_q : src_q) + (32'(idx_q) << 2);
  assign mem_wdata  = buf_q[idx_q];
  assign sink_valid = (state_q == S_RDWAIT) && mem_rsp_valid && !lb_q;
  assign sink_data  = mem_rdata;
  assign pop        = (state_q == S_RETIRE);
  assign lb_active  = lb_q;

endmodule

// File: rtl/qdma_loop.sv
module qdma_loop
  import qdma_pkg::*;
#(
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned BURST_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rdata,
  output logic        sink_valid,
  output logic [31:0] sink_data,
  output logic        irq
);

  localparam int unsigned BURST_WORDS = BURST_BYTES / 4;

  // named internal events
  logic        ev_push, ev_retire, ev_overflow;
  logic        q_full, q_empty;
  logic        loop_cfg, lb_active;
  logic [31:0] mask_q;
  logic [2:0]  stat_q;
  qdma_cmd_t   push_cmd, head;

  qdma_regs u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .q_full, .q_empty, .ev_retire,
    .push(ev_push), .push_cmd, .ev_overflow, .loop_cfg,
    .mask_q, .stat_q, .irq
  );

  qdma_cmdq #(.DEPTH(DEPTH)) u_cmdq (
    .clk, .rst_n, .push(ev_push), .push_cmd, .pop(ev_retire),
    .head, .full(q_full), .empty(q_empty)
  );

  qdma_mover #(.BURST_WORDS(BURST_WORDS)) u_mover (
    .clk, .rst_n, .head, .q_empty, .loop_cfg,
    .pop(ev_retire), .lb_active,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rsp_valid, .mem_rdata,
    .sink_valid, .sink_data
  );

endmodule

// File: rtl/qdma_loop_chk.sv
module qdma_loop_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_rsp_valid,
  input logic        sink_valid,
  input logic        irq,
  input logic        ev_push,
  input logic        ev_retire,
  input logic        q_full,
  input logic        q_empty,
  input logic        lb_active,
  input logic [31:0] mask_q,
  input logic [2:0]  stat_q
);

  logic pend_q;
  always_ff @(posedge clk) begin
    if (!rst_n)             pend_q <= 1'b0;
    else if (mem_req)       pend_q <= 1'b1;
    else if (mem_rsp_valid) pend_q <= 1'b0;
  end

  // R11
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !pend_q);

  // R6
  retire_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retire |=> (stat_q[1] && stat_q[0]));

  // R8
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push && q_full) |=> stat_q[2]);

  // R7
  full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));

  // R4
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> lb_active);

  // R4
  sink_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sink_valid |-> !lb_active);

  // R9
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q[14:12]) |-> !irq);

  // R5
  retire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retire |-> !q_empty);

endmodule

bind qdma_loop qdma_loop_chk i_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_rsp_valid(mem_rsp_valid), .sink_valid(sink_valid), .irq(irq),
  .ev_push(ev_push), .ev_retire(ev_retire), .q_full(q_full),
  .q_empty(q_empty), .lb_active(lb_active), .mask_q(mask_q), .stat_q(stat_q)
);

// File: tb/test_qdma_loop.sv
`timescale 1ns/1ps
module test_qdma_loop;

  localparam int BW = 4;  // burst cap in words for this bench

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, sink_valid, irq;
  logic [31:0] mem_addr, mem_wdata, sink_data;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  qdma_loop #(.DEPTH(4), .BURST_BYTES(BW*4)) i_qdma_loop (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rsp_valid, .mem_rdata,
    .sink_valid, .sink_data, .irq
  );

  int checks = 0, fails = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] patt(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // memory model and logs
  logic        stall = 1'b0;
  logic        pend = 1'b0;
  logic        pend_we = 1'b0;
  logic [31:0] pend_addr = '0;
  int          lat = 0, nreq = 0;
  int          lg_n = 0, sk_n = 0;
  logic        lg_we   [64];
  logic [31:0] lg_addr [64];
  logic [31:0] lg_data [64];
  logic [31:0] sk_data [64];

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend && !stall) begin
      if (lat <= 1) begin
        mem_rsp_valid = 1'b1;
        mem_rdata = pend_we ? 32'h0 : patt(pend_addr);
        pend = 1'b0;
      end else lat--;
    end
    if (rst_n && mem_req) begin
      chk(!pend, "R11 request while outstanding", {31'b0, pend}, 32'h0);
      if (lg_n < 64) begin
        lg_we[lg_n] = mem_we; lg_addr[lg_n] = mem_addr; lg_data[lg_n] = mem_wdata;
      end
      lg_n++;
      pend = 1'b1; pend_we = mem_we; pend_addr = mem_addr;
      lat = 1 + (nreq % 3);
      nreq++;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && sink_valid) begin
      if (sk_n < 64) sk_data[sk_n] = sink_data;
      sk_n++;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_empty();
    logic [31:0] q;
    forever begin
      @(negedge clk);
      rd(5'h18, q);
      if (q[30]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_cmd(input logic lb, input logic [31:0] src, input logic [31:0] dst,
                         input int sl, input int dl);
    logic        e_we   [64];
    logic [31:0] e_addr [64];
    logic [31:0] e_data [64];
    int ne, nr, sr, dr, n;
    logic [31:0] s, d, v;
    ne = 0; nr = 0; s = src & ~32'h3; d = dst & ~32'h3; sr = sl; dr = dl;
    while (sr > 0 && !(lb && dr == 0)) begin
      n = (sr < BW) ? sr : BW;
      if (lb && dr < n) n = dr;
      for (int i = 0; i < n; i++) begin
        e_we[ne] = 1'b0; e_addr[ne] = s + 4*i; e_data[ne] = 0; ne++; nr++;
      end
      if (lb) for (int i = 0; i < n; i++) begin
        e_we[ne] = 1'b1; e_addr[ne] = d + 4*i; e_data[ne] = patt(s + 4*i); ne++;
      end
      s += 4*n; sr -= n;
      if (lb) begin d += 4*n; dr -= n; end
    end
    lg_n = 0; sk_n = 0;
    wr(5'h1C, {27'b0, lb, 4'b0});
    wr(5'h00, src);
    wr(5'h04, dst);
    wr(5'h08, sl);
    wr(5'h0C, dl);
    wait_empty();
    chk(lg_n == ne, "R3 request count", lg_n, ne);
    for (int i = 0; i < ne && i < lg_n; i++) begin
      chk(lg_we[i] == e_we[i], "R4 request kind", {31'b0, lg_we[i]}, {31'b0, e_we[i]});
      chk(lg_addr[i] == e_addr[i], "R3 request address (R1 alignment)", lg_addr[i], e_addr[i]);
      if (e_we[i]) chk(lg_data[i] == e_data[i], "R4 loopback write data", lg_data[i], e_data[i]);
    end
    chk(sk_n == (lb ? 0 : nr), "R4 sink word count", sk_n, lb ? 0 : nr);
    if (!lb) for (int i = 0; i < nr && i < sk_n; i++)
      chk(sk_data[i] == patt(e_addr[i]), "R4 sink data", sk_data[i], patt(e_addr[i]));
    rd(5'h10, v);
    chk(v == 32'h0000_3000, "R6 R5 done bits after retire", v, 32'h0000_3000);
    wr(5'h10, 32'h0000_3000);
    rd(5'h10, v);
    chk(v == 32'h0, "R9 write-one clears status", v, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(5'h18, v); chk(v == 32'h4000_0000, "R7 queue status at reset", v, 32'h4000_0000);
    rd(5'h14, v); chk(v == 32'hFFFF_FFFF, "R9 mask at reset", v, 32'hFFFF_FFFF);
    rd(5'h10, v); chk(v == 32'h0, "R6 status at reset", v, 32'h0);
    chk(irq == 1'b0, "R9 irq at reset", {31'b0, irq}, 32'h0);

    // R2 length width
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, v);
    chk(v == 32'h07FF_FFFF, "R2 source length bits", v, 32'h07FF_FFFF);
    wr(5'h0C - 5'h0C + 5'h08, 32'h0);
    // R1 no queueing from other offsets
    rd(5'h18, v); chk(v == 32'h4000_0000, "R1 length write does not queue", v, 32'h4000_0000);

    // R10 misc register
    wr(5'h1C, 32'hFFFF_FFFF); rd(5'h1C, v);
    chk(v == 32'h0000_0010, "R10 misc writable bits", v, 32'h10);
    wr(5'h1C, 32'h0);

    // R9 interrupt masking
    run_cmd(1'b0, 32'h0000_1001, 32'h0008_0003, 1, 1);
    wr(5'h00, 32'h0); // no effect on status
    lg_n = 0;
    wr(5'h08, 2); wr(5'h0C, 2); wait_empty();
    chk(irq == 1'b0, "R9 irq low with full mask", {31'b0, irq}, 32'h0);
    wr(5'h14, 32'hFFFF_DFFF);
    chk(irq == 1'b1, "R9 irq with bit 13 unmasked", {31'b0, irq}, 32'h1);
    wr(5'h10, 32'h0000_2000);
    chk(irq == 1'b0, "R9 irq after clearing bit 13", {31'b0, irq}, 32'h0);
    rd(5'h10, v); chk(v == 32'h0000_1000, "R9 only written bit cleared", v, 32'h1000);
    wr(5'h10, 32'h0000_1000);
    wr(5'h14, 32'hFFFF_FFFF);

    // sweep of lengths, both modes (R3 R4 R5 R6)
    for (int lb = 0; lb < 2; lb++)
      for (int sl = 0; sl <= 6; sl++)
        for (int dl = 0; dl <= 6; dl++)
          run_cmd(lb[0], 32'h0000_2003 + 32'(sl << 8), 32'h0004_0001 + 32'(dl << 8), sl, dl);

    // queue full and overflow (R7 R8), order (R6)
    stall = 1'b1; lg_n = 0; sk_n = 0;
    wr(5'h1C, 32'h0);
    wr(5'h08, 1);
    for (int k = 0; k < 5; k++) begin
      wr(5'h00, 32'h0000_3000 + 32'(k * 16));
      wr(5'h0C, 1);
      if (k == 3) begin
        rd(5'h18, v); chk(v == 32'h8000_0000, "R7 queue full", v, 32'h8000_0000);
      end
    end
    rd(5'h10, v); chk(v == 32'h0000_4000, "R8 overflow bit", v, 32'h4000);
    chk(irq == 1'b0, "R9 overflow masked", {31'b0, irq}, 32'h0);
    wr(5'h14, 32'hFFFF_BFFF);
    chk(irq == 1'b1, "R9 R8 overflow unmasked", {31'b0, irq}, 32'h1);
    wr(5'h10, 32'h0000_4000);
    chk(irq == 1'b0, "R9 overflow cleared", {31'b0, irq}, 32'h0);
    wr(5'h14, 32'hFFFF_FFFF);
    stall = 1'b0;
    wait_empty();
    chk(lg_n == 4, "R8 dropped command not run", lg_n, 4);
    for (int k = 0; k < 4 && k < lg_n; k++)
      chk(lg_addr[k] == 32'h0000_3000 + 32'(k * 16), "R6 queue order", lg_addr[k],
          32'h0000_3000 + 32'(k * 16));
    wr(5'h10, 32'h0000_7000);
    rd(5'h18, v); chk(v == 32'h4000_0000, "R7 empty after drain", v, 32'h4000_0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule